// File: doc/BRIEF.md
# Chip-Select Address Match Decoder

This block decides, for every external bus cycle, which memory region the cycle's address falls into. It holds ten programmable regions: eight for static chip-select devices and two for DRAM blocks. Each region has a base address, a don't-care mask and a small set of attributes. While a bus cycle is requested, the block drives the matching chip-select or DRAM-select strobe. It also reports the port width, burst permission and termination source that the rest of the bus controller must use. When no region matches, or when more than one does, it falls back to safe defaults. When a DRAM region overlaps another DRAM region or a chip-select region, it raises an error.

The block also produces the active-low byte-select strobes. It derives them from the low address bits, the transfer size and the port width of the region that was hit, so that narrow devices see their data on the upper lanes of the data bus. The region settings are written through a single-cycle write port. The decision is taken on the rising clock edge, and the external strobes are launched on the following falling edge, so that they change during the low half of the clock.

Top module: `cs_decoder`

## Requirements
- R1: Region index 0..7 is chip-select 0..7 and index 8..9 is DRAM block 0..1. A region hits when its valid bit is set and address bits [31:16] equal the base over every bit whose mask bit is 0 (mask bit 1 means don't compare). A region with valid cleared never hits, and a write with an index of 10 or more changes nothing.
- R2: When no region hits, all selects stay high and the attributes take the fallback values: `cyc_psize` = 00 (32-bit), `cyc_burst` = 0 and `cyc_ext_term` = 1.
- R3: When two or more chip-select regions hit and no DRAM region does, every hitting `cs_n` bit goes low and the attributes take the fallback values.
- R4: When both DRAM regions hit, or a DRAM region and a chip-select region hit together, `cyc_err` = 1, both `dram_n` bits stay high, any hitting `cs_n` bits go low and the attributes take the fallback values.
- R5: When exactly one region hits, its select goes low and the attributes come from that region. `cyc_psize` is 00 for 32-bit, 01 for 8-bit and 10 for 16-bit. `cyc_burst` is the region's burst bit and `cyc_ext_term` is the inverse of its internal-termination bit.
- R6: On a 32-bit port, lane 0 (D[31:24]) is strobed by `bs_n[3]`, lane 1 by `bs_n[2]`, lane 2 by `bs_n[1]` and lane 3 (D[7:0]) by `bs_n[0]`. `bus_tsize` 00 is a byte at lane `addr[1:0]`, 01 is a 16-bit word on lanes 0-1 or 2-3 chosen by `addr[1]`, and 10 or 11 is a long word on all lanes.
- R7: A 16-bit port uses only lanes 0-1: a byte goes to lane `addr[0]`, and any wider access goes to lanes 0 and 1. An 8-bit port uses only lane 0.
- R8: The decision is captured on the rising edge at which `bus_req` is high. The attribute outputs update at that edge. `cs_n`, `dram_n`, `oe_n` and `bs_n` update only on the falling edge that follows it.
- R9: When no cycle was captured at the last rising edge, all active-low strobes are high, `cyc_err` = 0 and the attributes hold the fallback values.
- R10: `oe_n` goes low only for a read cycle in which at least one `cs_n` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Region write strobe |
| cfg_idx | input | 4 | Region index written |
| cfg_base | input | 16 | Base address bits [31:16] |
| cfg_mask | input | 16 | Don't-care mask for bits [31:16] |
| cfg_valid | input | 1 | Region enable |
| cfg_psize | input | 2 | Port width code |
| cfg_burst | input | 1 | Burst allowed |
| cfg_int_term | input | 1 | Termination generated internally |
| bus_req | input | 1 | Bus cycle in progress, address stable |
| bus_addr | input | 32 | Cycle address |
| bus_rd | input | 1 | 1 = read |
| bus_tsize | input | 2 | Transfer size code |
| cs_n | output | 8 | Chip selects, active low |
| dram_n | output | 2 | DRAM block selects, active low |
| oe_n | output | 1 | Output enable, active low |
| bs_n | output | 4 | Byte selects, active low |
| cyc_psize | output | 2 | Port width for the cycle |
| cyc_burst | output | 1 | Burst permitted |
| cyc_ext_term | output | 1 | Termination from outside |
| cyc_err | output | 1 | Overlap involving a DRAM region |

## Verification
A corrupted region register shows up at the select pins on the first falling edge after the next cycle to that address is captured. It appears as a missing, extra or wrong select, or as attributes that are wrong at the rising edge. A wrong count of hits shows up as the fallback attributes on a single hit, or as a region's own attributes on an overlap. A wrong lane calculation shows up on `bs_n` in the same half cycle as the selects. A stale capture register would leave strobes low after `bus_req` drops, and this is visible one full clock later.

// File: rtl/cs_decoder.sv
module cs_decoder #(
  parameter int AW  = 32,
  parameter int LSB = 16,
  parameter int NCS = 8,
  parameter int NDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [$clog2(NCS+NDR+1)-1:0] cfg_idx,
  input  logic [AW-LSB-1:0] cfg_base,
  input  logic [AW-LSB-1:0] cfg_mask,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_psize,
  input  logic              cfg_burst,
  input  logic              cfg_int_term,
  input  logic              bus_req,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_tsize,
  output logic [NCS-1:0]    cs_n,
  output logic [NDR-1:0]    dram_n,
  output logic              oe_n,
  output logic [3:0]        bs_n,
  output logic [1:0]        cyc_psize,
  output logic              cyc_burst,
  output logic              cyc_ext_term,
  output logic              cyc_err
);
  localparam int NREG = NCS + NDR;
  localparam int CW   = AW - LSB;
  localparam int IW   = $clog2(NREG + 1);
  localparam int NW   = $clog2(NREG + 1);

  localparam logic [1:0] PS32 = 2'b00;
  localparam logic [1:0] PS8  = 2'b01;
  localparam logic [1:0] PS16 = 2'b10;

  logic [CW-1:0] base_q [NREG];
  logic [CW-1:0] mask_q [NREG];
  logic [1:0]    ps_q   [NREG];
  logic [NREG-1:0] vld_q, bst_q, itm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      bst_q <= '0;
      itm_q <= '0;
      for (int i = 0; i < NREG; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
        ps_q[i]   <= PS32;
      end
    end else if (cfg_we && (cfg_idx < IW'(NREG))) begin
      base_q[cfg_idx] <= cfg_base;
      mask_q[cfg_idx] <= cfg_mask;
      ps_q[cfg_idx]   <= cfg_psize;
      vld_q[cfg_idx]  <= cfg_valid;
      bst_q[cfg_idx]  <= cfg_burst;
      itm_q[cfg_idx]  <= cfg_int_term;
    end
  end

  logic [NREG-1:0] hit;
  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign hit[g] = vld_q[g] &&
      (((bus_addr[AW-1:LSB] ^ base_q[g]) & ~mask_q[g]) == '0);
  end

  logic [NCS-1:0] cs_hit;
  logic [NDR-1:0] dr_hit;
  logic [NW-1:0]  ncs, ndr;
  logic           single, clash;
  assign cs_hit = hit[NCS-1:0];
  assign dr_hit = hit[NREG-1:NCS];
  assign ncs    = NW'($countones(cs_hit));
  assign ndr    = NW'($countones(dr_hit));
  assign single = (ncs + ndr) == NW'(1);
  assign clash  = (ndr > NW'(1)) || ((ndr != '0) && (ncs != '0));

  logic [1:0] sel_ps;
  logic       sel_bst, sel_itm;
  always_comb begin
    sel_ps  = PS32;
    sel_bst = 1'b0;
    sel_itm = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) begin
        sel_ps  = ps_q[i];
        sel_bst = bst_q[i];
        sel_itm = itm_q[i];
      end
    end
  end

  logic [1:0] eff_ps;
  assign eff_ps = single ? sel_ps : PS32;

  logic [3:0] lane;
  always_comb begin
    lane = 4'b0000;
    case (eff_ps)
      PS8:  lane = 4'b0001;
      PS16: begin
        if (bus_tsize == 2'b00) lane = bus_addr[0] ? 4'b0010 : 4'b0001;
        else                    lane = 4'b0011;
      end
      default: begin
        case (bus_tsize)
          2'b00:   lane = 4'b0001 << bus_addr[1:0];
          2'b01:   lane = bus_addr[1] ? 4'b1100 : 4'b0011;
          default: lane = 4'b1111;
        endcase
      end
    endcase
  end

  logic unused_addr;
  assign unused_addr = ^bus_addr[LSB-1:2];

  logic           busy_q, rd_q;
  logic [NCS-1:0] cs_q;
  logic [NDR-1:0] dr_q;
  logic [3:0]     lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      rd_q         <= 1'b0;
      cs_q         <= '0;
      dr_q         <= '0;
      lane_q       <= '0;
      cyc_psize    <= PS32;
      cyc_burst    <= 1'b0;
      cyc_ext_term <= 1'b1;
      cyc_err      <= 1'b0;
    end else if (bus_req) begin
      busy_q       <= 1'b1;
      rd_q         <= bus_rd;
      cs_q         <= cs_hit;
      dr_q         <= clash ? '0 : dr_hit;
      lane_q       <= lane;
      cyc_psize    <= eff_ps;
      cyc_burst    <= single && !clash && sel_bst;
      cyc_ext_term <= !(single && !clash && sel_itm);
      cyc_err      <= clash;
    end else begin
      busy_q       <= 1'b0;
      rd_q         <= 1'b0;
      cs_q         <= '0;
      dr_q         <= '0;
      lane_q       <= '0;
      cyc_psize    <= PS32;
      cyc_burst    <= 1'b0;
      cyc_ext_term <= 1'b1;
      cyc_err      <= 1'b0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n   <= '1;
      dram_n <= '1;
      oe_n   <= 1'b1;
      bs_n   <= 4'hF;
    end else begin
      cs_n   <= ~(cs_q & {NCS{busy_q}});
      dram_n <= ~(dr_q & {NDR{busy_q}});
      oe_n   <= ~(busy_q && rd_q && (cs_q != '0));
      bs_n   <= ~({lane_q[0], lane_q[1], lane_q[2], lane_q[3]} & {4{busy_q}});
    end
  end

  // R2
  fallback_on_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cs_n) && (&dram_n)) |-> (cyc_psize == PS32 && !cyc_burst && cyc_ext_term));

  // R3
  multi_cs_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~cs_n) > 1) |-> (cyc_psize == PS32 && !cyc_burst && cyc_ext_term));

  // R4
  clash_no_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_err |-> ((&dram_n) && cyc_ext_term && !cyc_burst));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> ((&cs_n) && (&dram_n) && (&bs_n) && oe_n && !cyc_err));

  // R10
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !(&cs_n));
endmodule

// File: tb/cs_decoder_tb_top.sv
module cs_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [15:0] cfg_base = '0, cfg_mask = '0;
  logic        cfg_valid = 1'b0, cfg_burst = 1'b0, cfg_int_term = 1'b0;
  logic [1:0]  cfg_psize = '0;
  logic        bus_req = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [1:0]  bus_tsize = '0;
  logic [7:0]  cs_n;
  logic [1:0]  dram_n;
  logic        oe_n;
  logic [3:0]  bs_n;
  logic [1:0]  cyc_psize;
  logic        cyc_burst, cyc_ext_term, cyc_err;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cs_decoder dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
    .cfg_valid(cfg_valid), .cfg_psize(cfg_psize), .cfg_burst(cfg_burst),
    .cfg_int_term(cfg_int_term),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_tsize(bus_tsize),
    .cs_n(cs_n), .dram_n(dram_n), .oe_n(oe_n), .bs_n(bs_n),
    .cyc_psize(cyc_psize), .cyc_burst(cyc_burst), .cyc_ext_term(cyc_ext_term),
    .cyc_err(cyc_err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] idx, logic [15:0] base, logic [15:0] mask,
                    logic vld, logic [1:0] ps, logic bst, logic itm);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_idx = idx; cfg_base = base; cfg_mask = mask;
    cfg_valid = vld; cfg_psize = ps; cfg_burst = bst; cfg_int_term = itm;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic access(string tag, logic [31:0] a, logic rd, logic [1:0] ts,
                        logic [7:0] ecs, logic [1:0] edr, logic eoe, logic [3:0] ebs,
                        logic [1:0] eps, logic ebst, logic eext, logic eerr);
    @(posedge clk); #2;
    bus_req = 1'b1; bus_addr = a; bus_rd = rd; bus_tsize = ts;
    @(posedge clk); #2;
    chk({tag, " R8 pins held before fall"}, {24'd0, cs_n}, 32'h0000_00FF);
    chk({tag, " R8 attr at rise"}, {30'd0, cyc_psize}, {30'd0, eps});
    #13;
    chk({tag, " cs_n"}, {24'd0, cs_n}, {24'd0, ecs});
    chk({tag, " dram_n"}, {30'd0, dram_n}, {30'd0, edr});
    chk({tag, " R10 oe_n"}, {31'd0, oe_n}, {31'd0, eoe});
    chk({tag, " bs_n"}, {28'd0, bs_n}, {28'd0, ebs});
    chk({tag, " attr"}, {28'd0, cyc_burst, cyc_ext_term, cyc_err, 1'b0},
        {28'd0, ebst, eext, eerr, 1'b0});
    @(posedge clk); #2;
    bus_req = 1'b0;
    @(posedge clk); #15;
    chk({tag, " R9 idle strobes"}, {17'd0, cs_n, dram_n, oe_n, bs_n},
        {17'd0, 8'hFF, 2'b11, 1'b1, 4'hF});
    chk({tag, " R9 idle attr"}, {27'd0, cyc_psize, cyc_burst, cyc_ext_term, cyc_err},
        {27'd0, 2'b00, 1'b0, 1'b1, 1'b0});
  endtask

  task automatic t_reset;
    chk("R9 reset strobes", {17'd0, cs_n, dram_n, oe_n, bs_n},
        {17'd0, 8'hFF, 2'b11, 1'b1, 4'hF});
    chk("R9 reset attr", {27'd0, cyc_psize, cyc_burst, cyc_ext_term, cyc_err},
        {27'd0, 2'b00, 1'b0, 1'b1, 1'b0});
  endtask

  task automatic t_config;
    wr(4'd0, 16'h1000, 16'h00FF, 1'b1, 2'b01, 1'b1, 1'b1);
    wr(4'd1, 16'h2000, 16'h0000, 1'b1, 2'b10, 1'b0, 1'b0);
    wr(4'd2, 16'h2000, 16'h0FFF, 1'b1, 2'b10, 1'b0, 1'b1);
    wr(4'd3, 16'h3000, 16'h0000, 1'b1, 2'b00, 1'b1, 1'b1);
    wr(4'd4, 16'h4900, 16'h0000, 1'b1, 2'b00, 1'b1, 1'b1);
    wr(4'd5, 16'h6000, 16'h0000, 1'b0, 2'b00, 1'b1, 1'b1);
    wr(4'd8, 16'h4000, 16'h00FF, 1'b1, 2'b00, 1'b1, 1'b1);
    wr(4'd9, 16'h4000, 16'h0FFF, 1'b1, 2'b00, 1'b1, 1'b1);
    wr(4'd12, 16'h7000, 16'h0000, 1'b1, 2'b01, 1'b1, 1'b1);
  endtask

  task automatic t_single_cs;
    access("R5 R7 cs0 8-bit byte", 32'h1000_0004, 1'b1, 2'b00,
           8'hFE, 2'b11, 1'b0, 4'b0111, 2'b01, 1'b1, 1'b0, 1'b0);
    access("R7 cs0 8-bit word clamp", 32'h10AB_0002, 1'b1, 2'b01,
           8'hFE, 2'b11, 1'b0, 4'b0111, 2'b01, 1'b1, 1'b0, 1'b0);
    access("R5 R7 cs2 16-bit byte odd", 32'h2100_0001, 1'b1, 2'b00,
           8'hFB, 2'b11, 1'b0, 4'b1011, 2'b10, 1'b0, 1'b0, 1'b0);
    access("R7 cs2 16-bit long", 32'h2100_0000, 1'b0, 2'b10,
           8'hFB, 2'b11, 1'b1, 4'b0011, 2'b10, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_lanes32;
    access("R6 byte lane3", 32'h3000_0003, 1'b0, 2'b00,
           8'hF7, 2'b11, 1'b1, 4'b1110, 2'b00, 1'b1, 1'b0, 1'b0);
    access("R6 byte lane1", 32'h3000_0001, 1'b1, 2'b00,
           8'hF7, 2'b11, 1'b0, 4'b1011, 2'b00, 1'b1, 1'b0, 1'b0);
    access("R6 word upper half", 32'h3000_0002, 1'b1, 2'b01,
           8'hF7, 2'b11, 1'b0, 4'b1100, 2'b00, 1'b1, 1'b0, 1'b0);
    access("R6 long", 32'h3000_0000, 1'b1, 2'b11,
           8'hF7, 2'b11, 1'b0, 4'b0000, 2'b00, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_multi;
    access("R3 cs1+cs2 overlap", 32'h2000_0000, 1'b0, 2'b01,
           8'hF9, 2'b11, 1'b1, 4'b0011, 2'b00, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_dram;
    access("R5 dram1 single", 32'h4800_0000, 1'b1, 2'b10,
           8'hFF, 2'b01, 1'b1, 4'b0000, 2'b00, 1'b1, 1'b0, 1'b0);
    access("R4 dram0+dram1 clash", 32'h4000_0010, 1'b1, 2'b10,
           8'hFF, 2'b11, 1'b1, 4'b0000, 2'b00, 1'b0, 1'b1, 1'b1);
    access("R4 dram1+cs4 clash", 32'h4900_0000, 1'b1, 2'b10,
           8'hEF, 2'b11, 1'b0, 4'b0000, 2'b00, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_nomatch;
    access("R2 unmapped", 32'h8000_0000, 1'b1, 2'b00,
           8'hFF, 2'b11, 1'b1, 4'b0111, 2'b00, 1'b0, 1'b1, 1'b0);
    access("R1 invalid cs5 ignored", 32'h6000_0000, 1'b1, 2'b10,
           8'hFF, 2'b11, 1'b1, 4'b0000, 2'b00, 1'b0, 1'b1, 1'b0);
    access("R1 index 12 write ignored", 32'h7000_0000, 1'b1, 2'b10,
           8'hFF, 2'b11, 1'b1, 4'b0000, 2'b00, 1'b0, 1'b1, 1'b0);
    access("R1 masked bit compared", 32'h1100_0000, 1'b1, 2'b00,
           8'hFF, 2'b11, 1'b1, 4'b0111, 2'b00, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    t_reset();
    rst_n = 1'b1;
    t_config();
    t_single_cs();
    t_lanes32();
    t_multi();
    t_dram();
    t_nomatch();
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule